// File: doc/BRIEF.md
# Page-Mode Parallel ROM Read Sequencer

This block sits between an on-chip request/acknowledge bus and an external asynchronous parallel ROM. It drives the ROM address lines, an active-low chip enable and an active-low output enable, waits a number of clock cycles derived from the ROM's nanosecond timing, and then samples the ROM data and returns it to the requester with a one-cycle data-valid pulse. Only one read is in flight at a time.

The sequencer remembers the page that is currently open on the ROM. A page is the group of words that share every address bit above the `PAGE_BITS` low offset bits. A read whose upper bits match the open page, with chip enable still asserted, uses the short in-page wait. Any other read uses the full random-access wait. After a response, the enables stay asserted for `KEEP_CYC` cycles so that a later request can still hit the page. If nothing arrives in that time, both enables are released, the page is forgotten, and a recovery gap lets the ROM outputs float before the next access. After reset the enables are held high for the power-up interval before any access can start.

Every wait is `ceil(t_ns / CLK_PERIOD_NS) + 1` cycles. The random wait covers the larger of the address and output-enable access times, plus the address skew. The page wait covers the page access time plus the skew. The recovery wait covers the output float time. The power-up wait covers the power-up hold. With the default parameters these are 12, 5, 4 and 21 cycles.

Top module: `rom_page_reader`

## Requirements
- R1: While reset is low and for PU_CYC (default 21) rising edges after reset is released, `rom_ce_n` and `rom_oe_n` are 1, `req_ready` is 0 and `rsp_valid` is 0; `req_ready` first reads 1 after the PU_CYC-th edge.
- R2: `req_ready` is 1 only when no read is in flight and no power-up or recovery wait is running; a request is taken on a rising edge where `req_valid` and `req_ready` are both 1.
- R3: A read taken while the enables are released is a random access: on the taking edge `rom_addr` gets `req_addr` and both enables go to 0, and the ROM data is sampled ACC_CYC (default 12) edges later.
- R4: A read whose bits above the low PAGE_BITS (default 2) offset bits equal those of the previous read, taken while the enables are still 0, is sampled PAGE_CYC (default 5) edges after the taking edge.
- R5: A read whose upper bits differ from the open page uses the ACC_CYC wait even though chip enable stayed asserted.
- R6: If no request is taken within KEEP_CYC (default 8) edges after the sampling edge, both enables go to 1 on the KEEP_CYC-th edge and the page is forgotten, so the next read is a random access; a request taken on that very edge still hits the page.
- R7: After the enables go to 1, `req_ready` stays 0 for DF_CYC (default 4) cycles, so chip enable is never asserted again less than 25 ns after it was released.
- R8: `rom_addr` does not change while a read is waiting for its data.
- R9: `rsp_valid` is 1 for exactly the one cycle after the sampling edge, and `rsp_data` holds the sampled word until the next sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_PERIOD_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | ADDR_W | Word address of the read |
| rsp_valid | output | 1 | One-cycle pulse: rsp_data is new |
| rsp_data | output | DATA_W | Word sampled from the ROM |
| rom_addr | output | ADDR_W | Address lines to the ROM |
| rom_ce_n | output | 1 | Chip enable to the ROM, active low |
| rom_oe_n | output | 1 | Output enable to the ROM, active low |
| rom_data | input | DATA_W | Data lines from the ROM |

## Verification
Every result is due at a fixed edge count from its cause. A taken request samples data ACC_CYC or PAGE_CYC edges later, and the pulse is seen in the following cycle. The page closes KEEP_CYC edges after a sample, `req_ready` comes back DF_CYC edges after a close, and it first appears PU_CYC edges after reset. The bench keeps an integer countdown model of these deadlines, advanced on each rising edge, and compares every output at the falling edge against it. Its ROM model returns inverted data until the nanosecond access times since the last address, page or enable change have passed. A sample taken even one cycle early therefore shows up as a data mismatch.

// File: rtl/rom_rd_pkg.sv
`timescale 1ns/1ps
package rom_rd_pkg;

  typedef enum logic [1:0] {
    ST_PWRUP   = 2'd0,
    ST_IDLE    = 2'd1,
    ST_WAIT    = 2'd2,
    ST_RECOVER = 2'd3
  } rd_state_e;

  // cycles needed to cover t_ns, plus one cycle of synchronization margin
  function automatic int unsigned wait_cycles(input int unsigned t_ns,
                                              input int unsigned clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns + 1;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rom_rd_timer.sv
`timescale 1ns/1ps
module rom_rd_timer #(
  parameter int unsigned W       = 5,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/rom_rd_page.sv
`timescale 1ns/1ps
module rom_rd_page #(
  parameter int unsigned UPPER_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               open_set,
  input  logic               open_clr,
  input  logic [UPPER_W-1:0] probe_upper,
  output logic               is_open,
  output logic               hit
);
  logic [UPPER_W-1:0] cur_upper;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_open   <= 1'b0;
      cur_upper <= '0;
    end else if (open_set) begin
      is_open   <= 1'b1;
      cur_upper <= probe_upper;
    end else if (open_clr) begin
      is_open   <= 1'b0;
    end
  end

  assign hit = is_open && (probe_upper == cur_upper);
endmodule

// File: rtl/rom_page_reader.sv
`timescale 1ns/1ps
module rom_page_reader
  import rom_rd_pkg::*;
#(
  parameter int unsigned ADDR_W        = 22,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned PAGE_BITS     = 2,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_POWERUP_NS  = 200,
  parameter int unsigned T_ACC_NS      = 100,
  parameter int unsigned T_PAGE_NS     = 25,
  parameter int unsigned T_OE_NS       = 25,
  parameter int unsigned T_DF_NS       = 25,
  parameter int unsigned T_SKEW_NS     = 10,
  parameter int unsigned KEEP_CYC      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  input  logic [DATA_W-1:0] rom_data
);
  localparam int unsigned ACC_CYC  = wait_cycles(max2(T_ACC_NS, T_OE_NS) + T_SKEW_NS, CLK_PERIOD_NS);
  localparam int unsigned PAGE_CYC = wait_cycles(T_PAGE_NS + T_SKEW_NS, CLK_PERIOD_NS);
  localparam int unsigned PU_CYC   = wait_cycles(T_POWERUP_NS, CLK_PERIOD_NS);
  localparam int unsigned DF_CYC   = wait_cycles(T_DF_NS, CLK_PERIOD_NS);
  localparam int unsigned CNT_MAX  = max2(max2(ACC_CYC, PAGE_CYC), max2(max2(PU_CYC, DF_CYC), KEEP_CYC));
  localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);
  localparam int unsigned UPPER_W  = ADDR_W - PAGE_BITS;

  rd_state_e  state, state_nx;

  // named internal events
  logic       accept, capture, close_evt, waiting, page_hit, page_open;
  logic       tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign waiting   = (state == ST_WAIT);
  assign capture   = waiting && tmr_expired;
  assign close_evt = (state == ST_IDLE) && page_open && !accept && tmr_expired;

  rom_rd_page #(.UPPER_W(UPPER_W)) u_page (
    .clk         (clk),
    .rst_n       (rst_n),
    .open_set    (accept),
    .open_clr    (close_evt),
    .probe_upper (req_addr[ADDR_W-1:PAGE_BITS]),
    .is_open     (page_open),
    .hit         (page_hit)
  );

  // one timer serves every wait: a phase loaded with N-1 lasts N cycles
  always_comb begin
    tmr_load = accept || capture || close_evt;
    if (accept)       tmr_val = page_hit ? CNT_W'(PAGE_CYC - 1) : CNT_W'(ACC_CYC - 1);
    else if (capture) tmr_val = CNT_W'(KEEP_CYC - 1);
    else              tmr_val = CNT_W'(DF_CYC - 1);
  end

  rom_rd_timer #(.W(CNT_W), .RST_VAL(PU_CYC - 1)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_PWRUP:   if (tmr_expired) state_nx = ST_IDLE;
      ST_IDLE:    if (accept) state_nx = ST_WAIT;
                  else if (close_evt) state_nx = ST_RECOVER;
      ST_WAIT:    if (capture) state_nx = ST_IDLE;
      ST_RECOVER: if (tmr_expired) state_nx = ST_IDLE;
      default:    state_nx = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_PWRUP;
      rom_addr  <= '0;
      rom_ce_n  <= 1'b1;
      rom_oe_n  <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      state     <= state_nx;
      rsp_valid <= capture;
      if (accept) begin
        rom_addr <= req_addr;
        rom_ce_n <= 1'b0;
        rom_oe_n <= 1'b0;
      end else if (close_evt) begin
        rom_ce_n <= 1'b1;
        rom_oe_n <= 1'b1;
      end
      if (capture) rsp_data <= rom_data;
    end
  end
endmodule

// File: rtl/rom_page_reader_chk.sv
`timescale 1ns/1ps
module rom_page_reader_chk
  import rom_rd_pkg::*;
#(
  parameter int unsigned ADDR_W        = 22,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_POWERUP_NS  = 200,
  parameter int unsigned T_ACC_NS      = 100,
  parameter int unsigned T_PAGE_NS     = 25,
  parameter int unsigned T_OE_NS       = 25,
  parameter int unsigned T_DF_NS       = 25,
  parameter int unsigned T_SKEW_NS     = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rom_ce_n,
  input logic              rom_oe_n,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              accept,
  input logic              capture,
  input logic              waiting,
  input logic              page_hit
);
  localparam int unsigned ACC_CYC  = wait_cycles(max2(T_ACC_NS, T_OE_NS) + T_SKEW_NS, CLK_PERIOD_NS);
  localparam int unsigned PAGE_CYC = wait_cycles(T_PAGE_NS + T_SKEW_NS, CLK_PERIOD_NS);
  localparam int unsigned PU_CYC   = wait_cycles(T_POWERUP_NS, CLK_PERIOD_NS);
  localparam int unsigned DF_CYC   = wait_cycles(T_DF_NS, CLK_PERIOD_NS);

  int unsigned since_rst, since_accept, ce_hi_age;
  logic        hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst    <= 0;
      since_accept <= 0;
      ce_hi_age    <= DF_CYC;
      hit_q        <= 1'b0;
    end else begin
      if (since_rst < PU_CYC) since_rst <= since_rst + 1;
      if (accept) begin
        since_accept <= 1;
        hit_q        <= page_hit;
      end else if (since_accept < ACC_CYC + 1) begin
        since_accept <= since_accept + 1;
      end
      if (!rom_ce_n)             ce_hi_age <= 0;
      else if (ce_hi_age < DF_CYC) ce_hi_age <= ce_hi_age + 1;
    end
  end

  // R1
  pwrup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < PU_CYC) |-> (rom_ce_n && rom_oe_n && !req_ready));

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !req_ready);

  // R3
  random_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !hit_q) |-> (since_accept == ACC_CYC));

  // R3
  sample_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!rom_ce_n && !rom_oe_n));

  // R4
  page_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && hit_q) |-> (since_accept == PAGE_CYC));

  // R6
  hit_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && page_hit) |-> !rom_ce_n);

  // R7
  float_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_ce_n && ce_hi_age < DF_CYC) |-> !req_ready);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && $past(waiting)) |-> $stable(rom_addr));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind rom_page_reader rom_page_reader_chk #(
  .ADDR_W        (ADDR_W),
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .T_POWERUP_NS  (T_POWERUP_NS),
  .T_ACC_NS      (T_ACC_NS),
  .T_PAGE_NS     (T_PAGE_NS),
  .T_OE_NS       (T_OE_NS),
  .T_DF_NS       (T_DF_NS),
  .T_SKEW_NS     (T_SKEW_NS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rom_ce_n  (rom_ce_n),
  .rom_oe_n  (rom_oe_n),
  .rom_addr  (rom_addr),
  .accept    (accept),
  .capture   (capture),
  .waiting   (waiting),
  .page_hit  (page_hit)
);

// File: tb/rom_page_reader_test.sv
`timescale 1ns/1ps
module rom_page_reader_test;
  localparam int AW = 22, DW = 16, PB = 2, PER = 10, KEEP = 8;

  function automatic int cyc_for(input int ns);
    int c = 0;
    while (c * PER < ns) c++;
    return c + 1;
  endfunction

  localparam int ACC  = cyc_for(110);
  localparam int PAGE = cyc_for(35);
  localparam int PU   = cyc_for(200);
  localparam int DF   = cyc_for(25);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rom_ce_n, rom_oe_n;
  logic [DW-1:0] rsp_data, rom_data;
  logic [AW-1:0] rom_addr;

  always #(PER/2) clk = ~clk;

  rom_page_reader uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_data(rom_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  function automatic logic [DW-1:0] romfn(input logic [AW-1:0] a);
    return DW'((32'(a) * 32'h9E37) ^ (32'(a) >> 3) ^ 32'h5A5A);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // ---------------- behavioural ROM with timing check ----------------
  longint t_addr = 0, t_upper = 0, t_ce = 0, t_rise = 0;
  bit have_rise = 0, seen_ce = 1;
  logic [AW-1:0] seen_addr = '0;
  initial rom_data = '0;

  always @(negedge clk) begin
    longint now, need;
    now = longint'($time);
    if (rom_addr != seen_addr) begin
      if (rom_addr[AW-1:PB] != seen_addr[AW-1:PB]) t_upper = now - PER/2;
      t_addr = now - PER/2;
      seen_addr = rom_addr;
    end
    if (!rom_ce_n && seen_ce) begin
      t_ce = now - PER/2;
      if (have_rise) chk(t_ce - t_rise >= 25, "R7 float gap", t_ce - t_rise, 25);
    end
    if (rom_ce_n && !seen_ce) begin
      t_rise = now - PER/2;
      have_rise = 1;
    end
    seen_ce = rom_ce_n;
    need = t_upper + 100;
    if (t_ce + 100 > need) need = t_ce + 100;
    if (t_addr + 25 > need) need = t_addr + 25;
    need += 10;
    rom_data = (!rom_ce_n && !rom_oe_n && now + PER/2 >= need) ? romfn(rom_addr) : ~romfn(rom_addr);
  end

  // ---------------- reference model (deadline countdowns) ----------------
  int pu_left = PU, rec_left = 0, due = -1, keep_left = 0;
  bit pg_open = 0, ready_exp = 0, ce_exp = 1, rv_exp = 0, have_rsp = 0, by_keep = 0;
  int open_upper = 0;
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] rd_exp = '0;
  string kind = "R3";

  always @(posedge clk) begin
    if (!rst_n) begin
      pu_left = PU; rec_left = 0; due = -1; keep_left = 0;
      pg_open = 0; ready_exp = 0; ce_exp = 1; rv_exp = 0;
    end else begin
      rv_exp = 0;
      if (pu_left > 0) pu_left--;
      else if (rec_left > 0) rec_left--;
      else if (due > 0) begin
        due--;
        if (due == 0) begin
          rv_exp = 1; rd_exp = romfn(cur_addr); have_rsp = 1;
          due = -1; keep_left = KEEP;
        end
      end else if (ready_exp && req_valid) begin
        if (pg_open && int'(req_addr >> PB) == open_upper) begin due = PAGE; kind = "R4"; end
        else begin due = ACC; kind = pg_open ? "R5" : (by_keep ? "R6" : "R3"); end
        cur_addr = req_addr; open_upper = int'(req_addr >> PB);
        pg_open = 1; ce_exp = 0; by_keep = 0;
      end else if (pg_open && keep_left > 0) begin
        keep_left--;
        if (keep_left == 0) begin
          pg_open = 0; ce_exp = 1; rec_left = DF; by_keep = 1;
        end
      end
      ready_exp = (pu_left == 0 && rec_left == 0 && due < 0);
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    string rt;
    if (!rst_n) begin
      chk(rom_ce_n && rom_oe_n, "R1 reset enables", {rom_ce_n, rom_oe_n}, 3);
      chk(!req_ready && !rsp_valid, "R1 reset ready/valid", {req_ready, rsp_valid}, 0);
    end else if (!done) begin
      rt = (pu_left > 0) ? "R1" : (rec_left > 0) ? "R7" : "R2";
      chk(req_ready == ready_exp, {rt, " ready"}, req_ready, ready_exp);
      rt = (pu_left > 0) ? "R1" : (by_keep ? "R6" : "R3");
      chk(rom_ce_n == ce_exp, {rt, " ce_n"}, rom_ce_n, ce_exp);
      chk(rom_oe_n == ce_exp, {rt, " oe_n"}, rom_oe_n, ce_exp);
      chk(rsp_valid == rv_exp, {kind, " rsp_valid timing"}, rsp_valid, rv_exp);
      if (rv_exp) chk(rsp_data == rd_exp, {kind, " sampled data"}, rsp_data, rd_exp);
      else if (have_rsp) chk(rsp_data == rd_exp, "R9 data held", rsp_data, rd_exp);
      if (due > 0) chk(rom_addr == cur_addr, "R8 address held", rom_addr, cur_addr);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic [AW-1:0] a);
    req_valid = 1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
  endtask

  localparam logic [AW-1:0] BASE = 22'h012340;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    issue(BASE);                 // R3 random after power-up (R1)
    issue(BASE + 1);             // R4 page hits back to back
    issue(BASE + 3);
    issue(BASE + 2);
    issue(BASE + 4);             // R5 upper bits change with ce held
    repeat (3) @(negedge clk);
    issue(BASE + 5);             // R4 hit after short idle
    repeat (KEEP - 1) @(negedge clk);
    issue(BASE + 6);             // R6 taken on the closing edge: still a hit
    repeat (KEEP) @(negedge clk);
    issue(BASE + 7);             // R6/R7 closed: random, waits out recovery
    repeat (KEEP + 2) @(negedge clk);
    issue(BASE + 4);             // R6 after close and full recovery
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      a = BASE + AW'(($urandom % 3) << PB) + AW'($urandom % 4);
      repeat ($urandom % 12) @(negedge clk);
      issue(a);
    end
    repeat (KEEP + DF + 4) @(negedge clk);
    finish_run();
  end
endmodule